// File: doc/BRIEF.md
# Packed trace word unpacker

This block sits behind a trace capture memory. Each 32-bit word read out of that memory holds one, two or three trace samples packed side by side, depending on how wide the trace port was when the data was captured. The unpacker takes those words over a valid/ready input, splits each into its samples, and hands the samples out one per transfer over a valid/ready output. Every sample carries a 3-bit pipeline status, a packet field zero-extended to 16 bits, a sync flag and a trigger flag.

The port width (4, 8 or 16 bits) and the port mode (normal, demultiplexed, multiplexed) are static configuration inputs, changed only while reset is held. A sample whose raw status equals the trigger code (parameter `TRIG_CODE`, default 3'b110) is rewritten as it passes: the trigger flag is raised and the status is replaced by the low three packet bits. Configurations the capture path cannot produce raise `cfg_err` and stop the unit from taking words.

Top module: `trace_unpack`

## Requirements
- R1: After reset with a legal configuration, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_width` = 2'b00 (4-bit port) each word gives three samples, taken from bits 7:0, then 15:8, then 23:16; within a sample the status is bits 2:0, the packet bits 6:3 and the sync bit 7.
- R3: With `cfg_width` = 2'b01 (8-bit port) each word gives two samples, from bits 11:0 then 23:12; status bits 2:0, packet bits 10:3, sync bit 11.
- R4: With `cfg_width` = 2'b10 (16-bit port) each word gives one sample from bits 19:0; status bits 2:0, packet bits 18:3, sync bit 19.
- R5: When a sample's raw status equals `TRIG_CODE`, `out_trig` is 1 and `out_status` equals packet bits 2:0; otherwise `out_trig` is 0 and `out_status` is the raw status.
- R6: `out_sync` is 1 exactly when the top bit of the sample is 1.
- R7: `out_packet` bits above the packet width of the selected port are 0.
- R8: `cfg_err` is 1 when `cfg_mode` is 2'b10 (multiplexed) or 2'b11, when `cfg_mode` is 2'b01 (demultiplexed) with any width other than 8-bit, or when `cfg_width` is 2'b11; `cfg_mode` 2'b00 is the normal mode. While `cfg_err` is 1, `in_ready` is 0 and no sample is produced.
- R9: A new word is taken only when no sample is pending or in the same cycle as the last sample of the current word is taken; `in_ready` is 0 otherwise.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Port width: 00 = 4-bit, 01 = 8-bit, 10 = 16-bit, 11 illegal |
| cfg_mode | input | 2 | Port mode: 00 normal, 01 demultiplexed, 10 multiplexed, 11 illegal |
| cfg_err | output | 1 | Configuration unsupported |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit accepts an input word |
| in_data | input | 32 | Packed trace word |
| out_valid | output | 1 | Sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_status | output | 3 | Pipeline status (after trigger substitution) |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag |
| out_trig | output | 1 | Trigger flag |

## Verification
Random words are pushed through each of the three widths with both valid and ready toggling at random, so the sample order within a word, the lane boundaries and the field slices are all compared against a model that computes each sample arithmetically from the word. Random data hits the trigger code in roughly one sample in eight, which separates a correct substitution from one that keeps the raw status or takes the wrong packet bits. Frequent output stalls with new words waiting show whether a word is taken too early or a held sample changes, and the illegal port mode and width combinations are held with words offered to show that nothing is accepted.

// File: rtl/trace_unpack_pkg.sv
package trace_unpack_pkg;

  parameter int WORD_W = 32;
  parameter int USED_W = 24;
  parameter int ST_W   = 3;
  parameter int PKT_W  = 16;
  parameter int IDX_W  = 2;

  typedef enum logic [1:0] {
    PW_4    = 2'b00,
    PW_8    = 2'b01,
    PW_16   = 2'b10,
    PW_RSVD = 2'b11
  } port_width_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_DEMUX  = 2'b01,
    PM_MUX    = 2'b10,
    PM_RSVD   = 2'b11
  } port_mode_e;

  typedef struct packed {
    logic [ST_W-1:0]  status;
    logic [PKT_W-1:0] packet;
    logic             sync;
    logic             trig;
  } sample_t;

endpackage

// File: rtl/trace_unpack_lane.sv
module trace_unpack_lane
  import trace_unpack_pkg::*;
#(
  parameter int          LANE_W    = 8,
  parameter logic [2:0]  TRIG_CODE = 3'b110
) (
  input  logic [LANE_W-1:0] lane,
  output sample_t           smp
);

  localparam int PW = LANE_W - ST_W - 1;

  logic [ST_W-1:0]  raw_st;
  logic [PKT_W-1:0] pk;
  logic             hit;

  always_comb begin
    raw_st       = lane[ST_W-1:0];
    pk           = '0;
    pk[PW-1:0]   = lane[LANE_W-2:ST_W];
    hit          = (raw_st == TRIG_CODE);
    smp.packet   = pk;
    smp.sync     = lane[LANE_W-1];
    smp.trig     = hit;
    smp.status   = hit ? pk[ST_W-1:0] : raw_st;
  end

endmodule

// File: rtl/trace_unpack_cfg.sv
module trace_unpack_cfg
  import trace_unpack_pkg::*;
(
  input  logic [1:0] cfg_width,
  input  logic [1:0] cfg_mode,
  output logic       bad
);

  port_width_e w;
  port_mode_e  m;

  always_comb begin
    w   = port_width_e'(cfg_width);
    m   = port_mode_e'(cfg_mode);
    bad = 1'b0;
    if (w == PW_RSVD) bad = 1'b1;
    case (m)
      PM_NORMAL: ;
      PM_DEMUX:  if (w != PW_8) bad = 1'b1;
      default:   bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/trace_unpack_seq.sv
module trace_unpack_seq
  import trace_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              block,
  input  logic              in_valid,
  input  logic [USED_W-1:0] in_word,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              hold_valid,
  output logic [USED_W-1:0] hold_word,
  output logic [IDX_W-1:0]  hold_idx
);

  logic              valid_q, valid_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [USED_W-1:0] word_q;
  logic [IDX_W-1:0]  last_idx;
  logic              fire_out, done, fire_in, word_en, idx_en;

  always_comb begin
    case (port_width_e'(cfg_width))
      PW_4:    last_idx = IDX_W'(2);
      PW_8:    last_idx = IDX_W'(1);
      default: last_idx = IDX_W'(0);
    endcase
    fire_out = valid_q & out_ready;
    done     = fire_out & (idx_q == last_idx);
    in_ready = ~block & (~valid_q | done);
    fire_in  = in_valid & in_ready;
    word_en  = fire_in;
    idx_en   = fire_in | fire_out;
    valid_d  = valid_q;
    idx_d    = idx_q;
    if (fire_in) begin
      valid_d = 1'b1;
      idx_d   = '0;
    end else if (done) begin
      valid_d = 1'b0;
      idx_d   = '0;
    end else if (fire_out) begin
      idx_d   = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (idx_en)  idx_q  <= idx_d;
      if (word_en) word_q <= in_word;
    end
  end

  assign hold_valid = valid_q;
  assign hold_word  = word_q;
  assign hold_idx   = idx_q;

endmodule

// File: rtl/trace_unpack.sv
module trace_unpack
  import trace_unpack_pkg::*;
#(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_width,
  input  logic [1:0]           cfg_mode,
  output logic                 cfg_err,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ST_W-1:0]      out_status,
  output logic [PKT_W-1:0]     out_packet,
  output logic                 out_sync,
  output logic                 out_trig
);

  localparam int N4  = 3;
  localparam int L4  = 8;
  localparam int N8  = 2;
  localparam int L8  = 12;
  localparam int L16 = 20;

  logic              bad;
  logic              hold_valid;
  logic [USED_W-1:0] hold_word;
  logic [IDX_W-1:0]  hold_idx;
  logic              unused_hi;
  sample_t           s4 [N4];
  sample_t           s8 [N8];
  sample_t           s16;
  sample_t           sel;

  assign unused_hi = ^in_data[WORD_W-1:USED_W];

  trace_unpack_cfg u_cfg (
    .cfg_width (cfg_width),
    .cfg_mode  (cfg_mode),
    .bad       (bad)
  );

  trace_unpack_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width),
    .block      (bad),
    .in_valid   (in_valid),
    .in_word    (in_data[USED_W-1:0]),
    .in_ready   (in_ready),
    .out_ready  (out_ready),
    .hold_valid (hold_valid),
    .hold_word  (hold_word),
    .hold_idx   (hold_idx)
  );

  for (genvar g = 0; g < N4; g++) begin : g_l4
    trace_unpack_lane #(.LANE_W(L4), .TRIG_CODE(TRIG_CODE)) u_lane (
      .lane (hold_word[g*L4 +: L4]),
      .smp  (s4[g])
    );
  end

  for (genvar g = 0; g < N8; g++) begin : g_l8
    trace_unpack_lane #(.LANE_W(L8), .TRIG_CODE(TRIG_CODE)) u_lane (
      .lane (hold_word[g*L8 +: L8]),
      .smp  (s8[g])
    );
  end

  trace_unpack_lane #(.LANE_W(L16), .TRIG_CODE(TRIG_CODE)) u_l16 (
    .lane (hold_word[L16-1:0]),
    .smp  (s16)
  );

  always_comb begin
    case (port_width_e'(cfg_width))
      PW_4: begin
        case (hold_idx)
          2'd0:    sel = s4[0];
          2'd1:    sel = s4[1];
          default: sel = s4[2];
        endcase
      end
      PW_8:    sel = hold_idx[0] ? s8[1] : s8[0];
      default: sel = s16;
    endcase
  end

  assign cfg_err    = bad;
  assign out_valid  = hold_valid;
  assign out_status = sel.status;
  assign out_packet = sel.packet;
  assign out_sync   = sel.sync;
  assign out_trig   = sel.trig;

endmodule

// File: rtl/trace_unpack_chk.sv
module trace_unpack_chk
  import trace_unpack_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_width,
  input logic             cfg_err,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ST_W-1:0]  out_status,
  input logic [PKT_W-1:0] out_packet,
  input logic             out_sync,
  input logic             out_trig
);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_status) &&
      $stable(out_packet) && $stable(out_sync) && $stable(out_trig));

  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !in_ready && !out_valid);

  p_no_early_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_trig_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trig |-> out_status == out_packet[ST_W-1:0]);

  p_pkt_ext4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_width == 2'b00 |-> out_packet[PKT_W-1:4] == '0);

  p_pkt_ext8_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_width == 2'b01 |-> out_packet[PKT_W-1:8] == '0);

endmodule

bind trace_unpack trace_unpack_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_width  (cfg_width),
  .cfg_err    (cfg_err),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_status (out_status),
  .out_packet (out_packet),
  .out_sync   (out_sync),
  .out_trig   (out_trig)
);

// File: tb/tb_trace_unpack.sv
`timescale 1ns/1ps
module tb_trace_unpack;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_width;
  logic [1:0]  cfg_mode;
  logic        cfg_err;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_status;
  logic [15:0] out_packet;
  logic        out_sync;
  logic        out_trig;

  typedef struct {
    logic [2:0]  st;
    logic [15:0] pk;
    logic        sy;
    logic        tr;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  logic        pv_stall;
  logic [2:0]  pv_st;
  logic [15:0] pv_pk;
  logic        pv_sy, pv_tr;

  always #2.5 clk = ~clk;

  trace_unpack dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
    .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_packet(out_packet), .out_sync(out_sync),
    .out_trig(out_trig)
  );

  function automatic bit exp_err();
    if (cfg_width == 2'b11) return 1;
    if (cfg_mode == 2'b00) return 0;
    if (cfg_mode == 2'b01) return cfg_width != 2'b01;
    return 1;
  endfunction

  function automatic int n_per_word();
    if (cfg_width == 2'b00) return 3;
    if (cfg_width == 2'b01) return 2;
    return 1;
  endfunction

  function automatic exp_t make_sample(logic [31:0] w, int k);
    int L;
    int off;
    longint v;
    exp_t e;
    if (cfg_width == 2'b00) begin L = 8;  off = 8 * k;  end
    else if (cfg_width == 2'b01) begin L = 12; off = 12 * k; end
    else begin L = 20; off = 0; end
    v = (longint'(w) >> off) % (longint'(1) << L);
    e.st = 3'(v % 8);
    e.pk = 16'((v / 8) % (longint'(1) << (L - 4)));
    e.sy = 1'((v >> (L - 1)) % 2);
    e.tr = 1'b0;
    if (e.st == 3'b110) begin
      e.tr = 1'b1;
      e.st = 3'(e.pk % 8);
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string width_req();
    if (cfg_width == 2'b00) return "R2";
    if (cfg_width == 2'b01) return "R3";
    return "R4";
  endfunction

  // Model update at the clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      bit ir;
      logic [31:0] w;
      ir = !exp_err() && (q.size() == 0 || (out_ready && q.size() == 1));
      w = in_data;
      if (q.size() > 0 && out_ready) void'(q.pop_front());
      if (in_valid && ir)
        for (int k = 0; k < n_per_word(); k++) q.push_back(make_sample(w, k));
    end
  end

  task automatic compare();
    bit ir_e;
    ir_e = !exp_err() && (q.size() == 0 || (out_ready && q.size() == 1));
    check(cfg_err == exp_err(), "R8", "cfg_err", cfg_err, exp_err());
    check(in_ready == ir_e, exp_err() ? "R8" : "R9", "in_ready", in_ready, ir_e);
    check(out_valid == (q.size() > 0), "R9", "out_valid", out_valid, q.size() > 0);
    if (pv_stall) begin
      check(out_valid && out_status == pv_st && out_packet == pv_pk &&
            out_sync == pv_sy && out_trig == pv_tr, "R10", "held sample",
            {out_status, out_packet}, {pv_st, pv_pk});
    end
    if (out_valid && q.size() > 0) begin
      exp_t e;
      e = q[0];
      check(out_status == e.st, e.tr ? "R5" : width_req(), "status", out_status, e.st);
      check(out_packet == e.pk, "R7", "packet", out_packet, e.pk);
      check(out_sync == e.sy, "R6", "sync", out_sync, e.sy);
      check(out_trig == e.tr, "R5", "trig", out_trig, e.tr);
    end
    pv_stall = out_valid && !out_ready;
    pv_st = out_status; pv_pk = out_packet; pv_sy = out_sync; pv_tr = out_trig;
  endtask

  task automatic do_reset(logic [1:0] w, logic [1:0] m);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_data = '0;
    cfg_width = w;
    cfg_mode = m;
    pv_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    if (!exp_err()) begin
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = ($urandom % 4) != 0;
      in_data   = $urandom;
      out_ready = ($urandom % 3) != 0;
      #1 compare();
    end
  endtask

  task automatic directed(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = 1'b0;
    #1 compare();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1 compare();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      #1 compare();
    end
  endtask

  initial begin
    do_reset(2'b00, 2'b00);
    directed(32'h00FE_B736);   // R2/R5: trigger codes in the first lanes
    run(400);
    do_reset(2'b01, 2'b00);
    directed(32'h0086_E00E);   // R3/R6
    run(400);
    do_reset(2'b01, 2'b01);
    run(300);
    do_reset(2'b10, 2'b00);
    directed(32'hFF0F_FFFE);   // R4/R7: high bits ignored
    run(400);
    do_reset(2'b10, 2'b01);    // R8: demux with 16-bit
    run(40);
    do_reset(2'b00, 2'b10);    // R8: multiplexed
    run(40);
    do_reset(2'b11, 2'b00);    // R8: illegal width
    run(40);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule